// File: doc/BRIEF.md
# Rotating Register File

This block is a register file with two combinational read ports and one write port, addressed by logical register specifiers. The specifier space is split in two. The lower part is fixed: a logical specifier there selects the physical register with the same number. The upper part rotates: a logical specifier there is offset by a rotating base before it selects a physical register. The offset addition wraps within the rotating part, whose size is a power of two.

Software-pipelined loops use this block to give each iteration fresh registers without unrolling. Every loop-closing branch pulses `loop_step`, and that pulse lowers the base by one. A value written under logical name r is therefore found under logical name r+k after k iterations. A producer with k cycles of latency in a one-iteration-per-cycle loop names its result k specifiers below its consumer. Before a loop starts, software sets the base with `base_set` and `base_set_val`, or clears it with reset.

Top module: `rotating_regfile`

## Requirements
- R1: After reset, the rotating base is 0 and every register reads as zero on both read ports.
- R2: A logical specifier below 32 (the fixed part, with default parameters) maps to the physical register of the same number, whatever the base.
- R3: A logical specifier s from 32 to 63 maps to physical register 32 + ((s - 32 + base) mod 32).
- R4: Each cycle with `loop_step` high and `base_set` low lowers the base by one, and the base wraps from 0 to 31. A value written to logical r is read as logical r+k after k steps.
- R5: `base_set` high loads `base_set_val` into the base on the next edge. When `loop_step` is high in the same cycle, the load wins.
- R6: A write or read issued in the same cycle as a `loop_step` pulse uses the base value from before the step.
- R7: A read of the physical register that is being written in the same cycle returns the new write data (write-through).
- R8: With `wr_en` low, no register changes. The two read ports select their registers independently.
- R9: The rotating offset wraps. At base 1, logical 63 maps to physical 32. At base 31, logical 32 maps to physical 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears the base and all registers |
| loop_step | input | 1 | Loop-branch strobe; lowers the base by one |
| base_set | input | 1 | Load command for the base |
| base_set_val | input | 5 | Value loaded into the base |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 6 | Logical write specifier |
| wr_data | input | 32 | Write data |
| rd0_spec | input | 6 | Logical specifier of read port 0 |
| rd0_data | output | 32 | Read port 0 data, combinational |
| rd1_spec | input | 6 | Logical specifier of read port 1 |
| rd1_data | output | 32 | Read port 1 data, combinational |

## Verification
The assertions check the following on every cycle:
- the base update rules: the step by one, the load and its priority over a step, and holding otherwise;
- that fixed specifiers translate to themselves;
- that rotating specifiers stay inside the rotating part;
- that a read matching the current write returns the write data.

The full modular mapping, and the renaming of a stored value across iterations, can only be seen through the bench's scenarios. These include a write and a later read through a shifted logical name, wrap at both ends of the base range, and write or read in the same cycle as a step.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
   // Next-state action of the rotating base.
   typedef enum logic [1:0] {
      BASE_HOLD = 2'd0,
      BASE_STEP = 2'd1,
      BASE_LOAD = 2'd2
   } base_op_e;

   function automatic base_op_e decode_base_op(input logic step, input logic load);
      if (load)      return BASE_LOAD;
      else if (step) return BASE_STEP;
      else           return BASE_HOLD;
   endfunction
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
   import rrf_pkg::*;
#(
   parameter int BASE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              load_i,
   input  logic [BASE_W-1:0] load_val_i,
   output logic [BASE_W-1:0] base_o
);
   localparam logic [BASE_W-1:0] ONE = BASE_W'(1);

   base_op_e          op;
   logic [BASE_W-1:0] base_q;
   logic [BASE_W-1:0] base_d;

   always_comb begin
      op = decode_base_op(step_i, load_i);
      unique case (op)
         BASE_LOAD: base_d = load_val_i;
         BASE_STEP: base_d = base_q - ONE;
         default:   base_d = base_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q <= '0;
      else        base_q <= base_d;
   end

   assign base_o = base_q;

   // R4: a step alone lowers the base by one (modulo)
   p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (base_q == $past(base_q) - ONE));
   // R5: a load wins over a step
   p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (base_q == $past(load_val_i)));
   // R4: with no command the base holds
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(base_q));
endmodule

// File: rtl/rrf_xlate.sv
module rrf_xlate #(
   parameter int SPEC_W    = 6,
   parameter int BASE_W    = 5,
   parameter int ROT_FIRST = 32
) (
   input  logic [SPEC_W-1:0] spec_i,
   input  logic [BASE_W-1:0] base_i,
   output logic [SPEC_W-1:0] phys_o
);
   localparam logic [SPEC_W-1:0] FIRST = SPEC_W'(ROT_FIRST);

   logic [SPEC_W-1:0] rel;
   logic [BASE_W-1:0] off;
   logic [SPEC_W-1:0] rot_phys;

   always_comb begin
      rel      = spec_i - FIRST;
      off      = rel[BASE_W-1:0] + base_i;
      rot_phys = FIRST + SPEC_W'(off);
   end

   generate
      if (ROT_FIRST == 0) begin : g_all_rot
         assign phys_o = rot_phys;
      end else begin : g_split
         assign phys_o = (spec_i < FIRST) ? spec_i : rot_phys;
      end
   endgenerate
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
   parameter int DATA_W        = 32,
   parameter int NUM_REGS      = 64,
   parameter int ADDR_W        = 6,
   parameter int NUM_RD        = 2,
   parameter bit WRITE_THROUGH = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en_i,
   input  logic [ADDR_W-1:0]              wr_addr_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_addr_i,
   output logic [NUM_RD-1:0][DATA_W-1:0]  rd_data_o
);
   logic [DATA_W-1:0] mem_q [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
      end else if (wr_en_i) begin
         mem_q[wr_addr_i] <= wr_data_i;
      end
   end

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         if (WRITE_THROUGH) begin : g_bypass
            assign rd_data_o[p] = (wr_en_i && (wr_addr_i == rd_addr_i[p]))
                                  ? wr_data_i : mem_q[rd_addr_i[p]];
            // R7: a read that hits the current write sees the new data
            p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en_i && (wr_addr_i == rd_addr_i[p])) |-> (rd_data_o[p] == wr_data_i));
         end else begin : g_plain
            assign rd_data_o[p] = mem_q[rd_addr_i[p]];
         end
      end
   endgenerate
endmodule

// File: rtl/rotating_regfile.sv
module rotating_regfile #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 64,
   parameter int ROT_REGS = 32,
   parameter bit WRITE_THROUGH = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          loop_step,
   input  logic                          base_set,
   input  logic [$clog2(ROT_REGS)-1:0]   base_set_val,
   input  logic                          wr_en,
   input  logic [$clog2(NUM_REGS)-1:0]   wr_spec,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic [$clog2(NUM_REGS)-1:0]   rd0_spec,
   output logic [DATA_W-1:0]             rd0_data,
   input  logic [$clog2(NUM_REGS)-1:0]   rd1_spec,
   output logic [DATA_W-1:0]             rd1_data
);
   localparam int SPEC_W    = $clog2(NUM_REGS);
   localparam int BASE_W    = $clog2(ROT_REGS);
   localparam int ROT_FIRST = NUM_REGS - ROT_REGS;
   localparam int NUM_RD    = 2;
   localparam int NUM_XL    = NUM_RD + 1;

   generate
      if (ROT_REGS < 2 || (ROT_REGS & (ROT_REGS - 1)) != 0) begin : g_bad_rot
         $error("ROT_REGS must be a power of two of at least 2");
      end
      if (ROT_REGS > NUM_REGS || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_num
         $error("NUM_REGS must be a power of two no smaller than ROT_REGS");
      end
   endgenerate

   logic [BASE_W-1:0]               base;
   logic [NUM_XL-1:0][SPEC_W-1:0]   spec_all;
   logic [NUM_XL-1:0][SPEC_W-1:0]   phys_all;
   logic [NUM_RD-1:0][SPEC_W-1:0]   rd_phys;
   logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

   rrf_base_ctrl #(.BASE_W(BASE_W)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (loop_step),
      .load_i     (base_set),
      .load_val_i (base_set_val),
      .base_o     (base)
   );

   assign spec_all[0] = wr_spec;
   assign spec_all[1] = rd0_spec;
   assign spec_all[2] = rd1_spec;

   generate
      for (genvar x = 0; x < NUM_XL; x++) begin : g_xl
         rrf_xlate #(
            .SPEC_W    (SPEC_W),
            .BASE_W    (BASE_W),
            .ROT_FIRST (ROT_FIRST)
         ) u_xl (
            .spec_i (spec_all[x]),
            .base_i (base),
            .phys_o (phys_all[x])
         );

         // R2: fixed specifiers are never renamed
         p_fixed_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (spec_all[x] < SPEC_W'(ROT_FIRST)) |-> (phys_all[x] == spec_all[x]));
         // R3: rotating specifiers stay in the rotating part
         p_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (spec_all[x] >= SPEC_W'(ROT_FIRST)) |-> (phys_all[x] >= SPEC_W'(ROT_FIRST)));
      end
      for (genvar r = 0; r < NUM_RD; r++) begin : g_rdmap
         assign rd_phys[r] = phys_all[r+1];
      end
   endgenerate

   rrf_storage #(
      .DATA_W        (DATA_W),
      .NUM_REGS      (NUM_REGS),
      .ADDR_W        (SPEC_W),
      .NUM_RD        (NUM_RD),
      .WRITE_THROUGH (WRITE_THROUGH)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (phys_all[0]),
      .wr_data_i (wr_data),
      .rd_addr_i (rd_phys),
      .rd_data_o (rd_data)
   );

   assign rd0_data = rd_data[0];
   assign rd1_data = rd_data[1];
endmodule

// File: tb/tb_rotating_regfile.sv
module tb_rotating_regfile;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        loop_step = 1'b0;
   logic        base_set = 1'b0;
   logic [4:0]  base_set_val = '0;
   logic        wr_en = 1'b0;
   logic [5:0]  wr_spec = '0;
   logic [31:0] wr_data = '0;
   logic [5:0]  rd0_spec = '0;
   logic [31:0] rd0_data;
   logic [5:0]  rd1_spec = '0;
   logic [31:0] rd1_data;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rotating_regfile dut (
      .clk(clk), .rst_n(rst_n), .loop_step(loop_step), .base_set(base_set),
      .base_set_val(base_set_val), .wr_en(wr_en), .wr_spec(wr_spec),
      .wr_data(wr_data), .rd0_spec(rd0_spec), .rd0_data(rd0_data),
      .rd1_spec(rd1_spec), .rd1_data(rd1_data)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_base(input logic [4:0] v);
      base_set = 1'b1; base_set_val = v;
      tick();
      base_set = 1'b0;
   endtask

   task automatic steps(input int k);
      for (int i = 0; i < k; i++) begin
         loop_step = 1'b1;
         tick();
         loop_step = 1'b0;
      end
   endtask

   task automatic write(input logic [5:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_spec = s; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic peek0(input string req, input logic [5:0] s, input logic [31:0] exp);
      rd0_spec = s; #1;
      check(req, rd0_data, exp);
   endtask

   task automatic peek1(input string req, input logic [5:0] s, input logic [31:0] exp);
      rd1_spec = s; #1;
      check(req, rd1_data, exp);
   endtask

   task automatic t_reset();
      peek0("R1 reset p0 spec0", 6'd0, 32'h0);
      peek1("R1 reset p1 spec31", 6'd31, 32'h0);
      peek0("R1 reset p0 spec32", 6'd32, 32'h0);
      peek1("R1 reset p1 spec63", 6'd63, 32'h0);
   endtask

   task automatic t_fixed();
      set_base(5'd0);
      write(6'd5, 32'hA0A0_0005);
      steps(3);
      peek0("R2 fixed after steps", 6'd5, 32'hA0A0_0005);
      set_base(5'd17);
      peek1("R2 fixed at base 17", 6'd5, 32'hA0A0_0005);
   endtask

   task automatic t_rotate();
      set_base(5'd0);
      write(6'd40, 32'hB0B0_0040);
      steps(3);
      peek0("R4 renamed r+3", 6'd43, 32'hB0B0_0040);
      peek1("R3 old name maps elsewhere", 6'd40, 32'h0);
   endtask

   task automatic t_wrap();
      set_base(5'd0);
      write(6'd63, 32'hC0C0_0063);
      steps(1);
      peek0("R9 base 31 spec 32", 6'd32, 32'hC0C0_0063);
      set_base(5'd1);
      write(6'd63, 32'hD0D0_0032);
      set_base(5'd0);
      peek1("R9 base 1 spec 63 -> phys 32", 6'd32, 32'hD0D0_0032);
   endtask

   task automatic t_load_priority();
      base_set = 1'b1; base_set_val = 5'd5; loop_step = 1'b1;
      tick();
      base_set = 1'b0; loop_step = 1'b0;
      write(6'd32, 32'hE0E0_0037);
      set_base(5'd0);
      peek0("R5 load beats step", 6'd37, 32'hE0E0_0037);
   endtask

   task automatic t_same_cycle_step();
      set_base(5'd0);
      wr_en = 1'b1; wr_spec = 6'd34; wr_data = 32'hF0F0_0034; loop_step = 1'b1;
      rd1_spec = 6'd36; #1;
      check("R6 read uses pre-step base", rd1_data, 32'h0);
      tick();
      wr_en = 1'b0; loop_step = 1'b0;
      peek0("R6 write used pre-step base", 6'd35, 32'hF0F0_0034);
      peek1("R6 base moved after step", 6'd34, 32'h0);
   endtask

   task automatic t_bypass();
      set_base(5'd0);
      wr_en = 1'b1; wr_spec = 6'd50; wr_data = 32'h1234_5050;
      rd0_spec = 6'd50; rd1_spec = 6'd40; #1;
      check("R7 write-through", rd0_data, 32'h1234_5050);
      check("R8 other port independent", rd1_data, 32'hB0B0_0040);
      tick();
      wr_en = 1'b0;
      peek0("R7 stored after edge", 6'd50, 32'h1234_5050);
   endtask

   task automatic t_no_write();
      set_base(5'd0);
      write(6'd33, 32'h5555_0033);
      wr_en = 1'b0; wr_spec = 6'd33; wr_data = 32'h6666_0033;
      tick();
      peek0("R8 disabled write ignored", 6'd33, 32'h5555_0033);
   endtask

   initial begin
      fork
         begin
            #(CLK_PERIOD * 100000);
            if (!finished) begin
               n_checks++; n_fails++;
               $display("FAIL watchdog: got timeout expected completion");
               $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
               $finish;
            end
         end
      join_none
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();
      t_reset();
      t_fixed();
      t_rotate();
      t_wrap();
      t_load_priority();
      t_same_cycle_step();
      t_bypass();
      t_no_write();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule